// File: doc/BRIEF.md
# Strobed PCM Serial Port with Mute

This block is the serial side of a voice codec channel. It moves one companded sample each way per frame over a three-wire synchronous link: a bit clock, an active-high strobe that marks the timeslot, and one data line in each direction. The block runs on a fast system clock. It samples the bit clock, the strobe and the serial input through a synchronizer, and acts on the edges it detects.

When the strobe rises, the block captures the parallel transmit byte and pulses a load handshake. It then shifts the byte out most significant bit first, one bit on each rising bit-clock edge. On each falling edge it shifts a received bit in, also MSB first. After the eighth falling edge it presents the received byte with a one-cycle valid pulse. The output driver is enabled only inside the timeslot; a pad buffer outside the block turns `serOut` and `serOutEn` into the tri-state line.

Two mute controls replace the outgoing or incoming sample with the negative-zero code of the selected companding law. A slot that is too long or too short never shifts more than one sample, and it never delivers a partial one.

Top module: `pcmStrobePort`

## Requirements
- R1: After reset is released with the strobe low, `serOutEn`, `rxValid` and `txLoad` are all 0.
- R2: Each rising edge of the strobe captures `txByte` and produces exactly one single-cycle `txLoad` pulse.
- R3: The captured byte appears on `serOut` MSB first, with bit 7-k valid after the (k+1)-th rising bit-clock edge of the slot.
- R4: `serIn` is sampled on falling bit-clock edges, MSB first. After the eighth falling edge, `rxByte` holds the sample and `rxValid` is high for exactly one cycle.
- R5: `serOutEn` is 1 only while a started slot's strobe is high, and it returns to 0 after the strobe falls.
- R6: When `txMute` is 1 at the strobe rise, the transmitted byte is 8'h55 if `lawSel`=1 (A-law) and 8'h7F if `lawSel`=0 (mu-law), whatever `txByte` holds.
- R7: When `rxMute` is 1, the delivered `rxByte` is 8'h55 if `lawSel`=1 and 8'h7F if `lawSel`=0, whatever was received.
- R8: In a slot longer than 8 bit clocks, only the first 8 bits are used. `serOut` holds the last bit, there is no second `rxValid`, and `rxByte` keeps the first-8-bit value.
- R9: A slot shorter than 8 bit clocks delivers no `rxValid`. The next slot starts again from bit 7 in both directions.
- R10: Bit-clock edges and `serIn` activity while the strobe is low leave `serOutEn` at 0 and produce no `rxValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial link |
| rstN | input | 1 | Active-low asynchronous reset |
| bitClk | input | 1 | Serial bit clock |
| strobe | input | 1 | Active-high timeslot marker |
| serIn | input | 1 | Serial receive data |
| txByte | input | 8 | Parallel sample to transmit |
| txMute | input | 1 | 1 replaces the transmit sample with negative zero |
| rxMute | input | 1 | 1 replaces the received sample with negative zero |
| lawSel | input | 1 | 1 selects A-law, 0 selects mu-law |
| serOut | output | 1 | Serial transmit data, meaningful while enabled |
| serOutEn | output | 1 | Output-enable for the tri-state pad |
| rxByte | output | 8 | Last delivered receive sample |
| rxValid | output | 1 | One-cycle pulse when `rxByte` is updated |
| txLoad | output | 1 | One-cycle pulse when `txByte` is captured |

## Verification
The main path runs all 256 transmit values, each paired with a different receive value, so that a swapped, reversed or shifted bit shows up as a byte mismatch in one direction or the other. All four mute-and-law combinations are run against a sample that differs from both negative-zero codes. This separates the two substitution codes and shows which direction each mute acts on. Ten-bit and five-bit slots exercise the bit-count limits. They are followed by a normal slot to show that counting restarts. Idle bit-clock toggling with the strobe low checks that nothing leaks outside the slot.

// File: rtl/pcmPortPkg.sv
package pcmPortPkg;
  // Per-cycle commands from control to datapath
  typedef struct packed {
    logic loadTx;   // strobe rose: capture parallel byte
    logic shiftTx;  // drive next transmit bit
    logic shiftRx;  // capture next receive bit
    logic lastRx;   // this capture completes the sample
    logic driveEn;  // slot open: enable output pad
  } portCtl_t;
endpackage

// File: rtl/pcmPortCtrl.sv
module pcmPortCtrl
  import pcmPortPkg::*;
#(
  parameter int SLOT_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     bitClk,
  input  logic     strobe,
  input  logic     serIn,
  output logic     serInS,
  output portCtl_t ctl
);
  localparam int CNT_W = $clog2(SLOT_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SLOT_BITS);

  logic [SYNC_STAGES-1:0] clkSync, strbSync, dinSync;
  logic clkS, strbS, clkPrev, strbPrev;
  logic bitRise, bitFall, strbRise;
  logic active;
  logic [CNT_W-1:0] txCnt, rxCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSync  <= '0;
      strbSync <= '0;
      dinSync  <= '0;
      clkPrev  <= 1'b0;
      strbPrev <= 1'b0;
    end else begin
      clkSync  <= {clkSync[SYNC_STAGES-2:0], bitClk};
      strbSync <= {strbSync[SYNC_STAGES-2:0], strobe};
      dinSync  <= {dinSync[SYNC_STAGES-2:0], serIn};
      clkPrev  <= clkS;
      strbPrev <= strbS;
    end
  end

  assign clkS     = clkSync[SYNC_STAGES-1];
  assign strbS    = strbSync[SYNC_STAGES-1];
  assign serInS   = dinSync[SYNC_STAGES-1];
  assign bitRise  = clkS & ~clkPrev;
  assign bitFall  = ~clkS & clkPrev;
  assign strbRise = strbS & ~strbPrev;

  always_comb begin
    ctl.loadTx  = strbRise;
    ctl.driveEn = active & strbS;
    ctl.shiftTx = bitRise & ctl.driveEn & (txCnt < CNT_MAX);
    ctl.shiftRx = bitFall & ctl.driveEn & (rxCnt < CNT_MAX);
    ctl.lastRx  = ctl.shiftRx & (rxCnt == CNT_MAX - 1'b1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      txCnt  <= '0;
      rxCnt  <= '0;
    end else if (strbRise) begin
      active <= 1'b1;
      txCnt  <= '0;
      rxCnt  <= '0;
    end else if (!strbS) begin
      active <= 1'b0;
    end else begin
      if (ctl.shiftTx) txCnt <= txCnt + 1'b1;
      if (ctl.shiftRx) rxCnt <= rxCnt + 1'b1;
    end
  end

  // R8
  tx_count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    txCnt <= CNT_MAX);

  // R8
  rx_count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxCnt <= CNT_MAX);

  // R9
  slot_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strbRise |=> (txCnt == '0 && rxCnt == '0 && active));

  // R10
  idle_no_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strbS |-> !(ctl.shiftTx || ctl.shiftRx));
endmodule

// File: rtl/pcmPortData.sv
module pcmPortData
  import pcmPortPkg::*;
#(
  parameter int SLOT_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  portCtl_t             ctl,
  input  logic                 serInS,
  input  logic [SLOT_BITS-1:0] txByte,
  input  logic                 txMute,
  input  logic                 rxMute,
  input  logic                 lawSel,
  output logic                 serOut,
  output logic                 serOutEn,
  output logic [SLOT_BITS-1:0] rxByte,
  output logic                 rxValid,
  output logic                 txLoad
);
  // Negative zero: mu-law all ones below sign; A-law with even-bit inversion
  function automatic logic [SLOT_BITS-1:0] negZero(input logic aLaw);
    logic [SLOT_BITS-1:0] code;
    for (int i = 0; i < SLOT_BITS; i++)
      code[i] = aLaw ? (i % 2 == 0) : (i != SLOT_BITS - 1);
    return code;
  endfunction

  logic [SLOT_BITS-1:0] txShift, rxShift, rxNext;

  assign rxNext = {rxShift[SLOT_BITS-2:0], serInS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift  <= '0;
      serOut   <= 1'b0;
      serOutEn <= 1'b0;
      txLoad   <= 1'b0;
    end else begin
      serOutEn <= ctl.driveEn;
      txLoad   <= ctl.loadTx;
      if (ctl.loadTx) begin
        txShift <= txMute ? negZero(lawSel) : txByte;
      end else if (ctl.shiftTx) begin
        serOut  <= txShift[SLOT_BITS-1];
        txShift <= {txShift[SLOT_BITS-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rxByte  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= ctl.lastRx;
      if (ctl.shiftRx) rxShift <= rxNext;
      if (ctl.lastRx)  rxByte  <= rxMute ? negZero(lawSel) : rxNext;
    end
  end

  // R6
  tx_mute_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadTx && txMute) |=> txShift == negZero($past(lawSel)));

  // R7
  rx_mute_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.lastRx && rxMute) |=> rxByte == negZero($past(lawSel)));

  // R4
  rx_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R2
  tx_load_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    txLoad |=> !txLoad);

  // R5
  en_follows_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.driveEn |=> !serOutEn);
endmodule

// File: rtl/pcmStrobePort.sv
module pcmStrobePort
  import pcmPortPkg::*;
#(
  parameter int SLOT_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bitClk,
  input  logic                 strobe,
  input  logic                 serIn,
  input  logic [SLOT_BITS-1:0] txByte,
  input  logic                 txMute,
  input  logic                 rxMute,
  input  logic                 lawSel,
  output logic                 serOut,
  output logic                 serOutEn,
  output logic [SLOT_BITS-1:0] rxByte,
  output logic                 rxValid,
  output logic                 txLoad
);
  portCtl_t ctl;
  logic     serInS;

  pcmPortCtrl #(.SLOT_BITS(SLOT_BITS), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .strobe(strobe),
    .serIn(serIn), .serInS(serInS), .ctl(ctl)
  );

  pcmPortData #(.SLOT_BITS(SLOT_BITS)) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .serInS(serInS),
    .txByte(txByte), .txMute(txMute), .rxMute(rxMute), .lawSel(lawSel),
    .serOut(serOut), .serOutEn(serOutEn), .rxByte(rxByte),
    .rxValid(rxValid), .txLoad(txLoad)
  );
endmodule

// File: tb/pcmStrobePort_tb.sv
module pcmStrobePort_tb;
  logic clk = 1'b0, rstN = 1'b0;
  logic bitClk = 1'b0, strobe = 1'b0, serIn = 1'b0;
  logic [7:0] txByte = 8'h00;
  logic txMute = 1'b0, rxMute = 1'b0, lawSel = 1'b0;
  logic serOut, serOutEn, rxValid, txLoad;
  logic [7:0] rxByte;

  int testsRun = 0, testsFailed = 0;
  int loadCount = 0, validCount = 0;
  logic [7:0] lastRx = 8'h00;
  bit finished = 0;

  always #2 clk = ~clk;

  pcmStrobePort u_dut (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .strobe(strobe), .serIn(serIn),
    .txByte(txByte), .txMute(txMute), .rxMute(rxMute), .lawSel(lawSel),
    .serOut(serOut), .serOutEn(serOutEn), .rxByte(rxByte),
    .rxValid(rxValid), .txLoad(txLoad)
  );

  always @(negedge clk) begin
    if (txLoad) loadCount++;
    if (rxValid) begin
      validCount++;
      lastRx = rxByte;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] nz(input logic aLaw);
    return aLaw ? 8'h55 : 8'h7F;
  endfunction

  // One slot with nBits bit clocks; returns the observed transmit byte
  task automatic runSlot(input logic [7:0] tx, input logic [7:0] rx, input int nBits,
                         input logic tm, input logic rm, input logic law,
                         output logic [7:0] seen, output int loads, output int valids,
                         output logic lastBit);
    int l0, v0;
    bit enOk;
    txByte = tx; txMute = tm; rxMute = rm; lawSel = law;
    tick(4);
    l0 = loadCount; v0 = validCount;
    strobe = 1'b1;
    tick(8);
    seen = 8'h00; enOk = 1; lastBit = 1'b0;
    for (int b = 0; b < nBits; b++) begin
      serIn = (b < 8) ? rx[7-b] : ~rx[0];
      bitClk = 1'b1;
      tick(8);
      if (!serOutEn) enOk = 0;
      if (b < 8) seen[7-b] = serOut;
      lastBit = serOut;
      bitClk = 1'b0;
      tick(8);
    end
    check(enOk, "R5 enable inside slot", 0, 1);
    strobe = 1'b0; serIn = 1'b0;
    tick(8);
    check(serOutEn == 1'b0, "R5 enable after slot", serOutEn, 0);
    loads = loadCount - l0;
    valids = validCount - v0;
  endtask

  initial begin
    logic [7:0] seen;
    int loads, valids;
    logic lastBit;
    tick(3);
    check(serOutEn == 0 && rxValid == 0 && txLoad == 0, "R1 reset outputs",
          {serOutEn, rxValid, txLoad}, 0);
    rstN = 1'b1;
    tick(4);
    check(serOutEn == 0 && rxValid == 0 && txLoad == 0, "R1 after release",
          {serOutEn, rxValid, txLoad}, 0);

    // R3/R4/R2: exhaustive transmit values, distinct receive values
    for (int i = 0; i < 256; i++) begin
      logic [7:0] rxv;
      rxv = 8'(i) ^ 8'hA6;
      runSlot(8'(i), rxv, 8, 1'b0, 1'b0, i[0], seen, loads, valids, lastBit);
      check(seen == 8'(i), "R3 transmit byte", seen, i);
      check(valids == 1 && lastRx == rxv, "R4 receive byte", lastRx, rxv);
      check(loads == 1, "R2 one load pulse", loads, 1);
    end

    // R6/R7: mute and law combinations
    for (int m = 0; m < 4; m++) begin
      logic law;
      law = m[0];
      runSlot(8'hC3, 8'h9A, 8, 1'b1, 1'b0, law, seen, loads, valids, lastBit);
      check(seen == nz(law), "R6 tx mute code", seen, nz(law));
      check(lastRx == 8'h9A, "R6 rx untouched by tx mute", lastRx, 8'h9A);
      runSlot(8'hC3, 8'h9A, 8, 1'b0, 1'b1, law, seen, loads, valids, lastBit);
      check(seen == 8'hC3, "R7 tx untouched by rx mute", seen, 8'hC3);
      check(valids == 1 && lastRx == nz(law), "R7 rx mute code", lastRx, nz(law));
    end

    // R8: long slot
    runSlot(8'hB4, 8'h2D, 10, 1'b0, 1'b0, 1'b0, seen, loads, valids, lastBit);
    check(seen == 8'hB4, "R8 long slot tx", seen, 8'hB4);
    check(lastBit == 1'b0, "R8 holds last bit", lastBit, 0);
    check(valids == 1 && lastRx == 8'h2D, "R8 long slot rx", lastRx, 8'h2D);

    // R9: short slot then normal slot
    runSlot(8'hFF, 8'hFF, 5, 1'b0, 1'b0, 1'b0, seen, loads, valids, lastBit);
    check(valids == 0, "R9 short slot no valid", valids, 0);
    check(lastRx == 8'h2D, "R9 rxByte kept", lastRx, 8'h2D);
    runSlot(8'h5A, 8'h81, 8, 1'b0, 1'b0, 1'b0, seen, loads, valids, lastBit);
    check(seen == 8'h5A && lastRx == 8'h81, "R9 restart after short",
          {seen, lastRx}, 16'h5A81);

    // R10: idle activity
    begin
      int v0;
      bit enSeen;
      v0 = validCount; enSeen = 0;
      for (int k = 0; k < 12; k++) begin
        serIn = k[1]; bitClk = 1'b1; tick(8);
        if (serOutEn) enSeen = 1;
        bitClk = 1'b0; tick(8);
        if (serOutEn) enSeen = 1;
      end
      check(!enSeen, "R10 no enable while idle", enSeen, 0);
      check(validCount == v0, "R10 no valid while idle", validCount - v0, 0);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule